// File: doc/BRIEF.md
# Clock Manager Status Monitor

This block builds the 8-bit status word of a clock manager. It tracks a signed fine phase-shift setting. Single-cycle increment and decrement strobes move the setting. Bit 0 of the word reports overflow. Overflow is raised when a request would push the setting past the allowed magnitude, or when the delay line reports that every tap is in use.

Bit 1 reports that the reference clock has stopped. The reference clock arrives already sampled in the system clock domain. The monitor counts system clocks since the last change of that sample. Once the count reaches a programmable stall limit, the stopped condition is set. The bit only shows when the feedback path is connected. The remaining bits are reserved and read as zero. The word is meant to be read directly by the surrounding clock-manager control logic.

Top module: `clkmgr_status_mon`

## Requirements
- R1: While `rst_ni` is low, and directly after it is released, `status_o` reads 8'h00. The phase-shift setting starts at 0.
- R2: Bits 7 to 2 of `status_o` always read 0.
- R3: An increment at +255, or a decrement at -255, is not applied. It sets bit 0 of `status_o` one clock later.
- R4: Once set by a rejected request, bit 0 stays set until an increment or decrement is accepted. Bit 0 then reads 0 one clock after the accepted request, provided `dly_full_i` is low.
- R5: When `ps_inc_i` and `ps_dec_i` are high in the same cycle, the setting does not change and the overflow state does not change.
- R6: With `dly_full_i` high, bit 0 reads 1 one clock later, whatever the setting is. After `dly_full_i` goes low, bit 0 follows the range overflow state alone.
- R7: With `fb_conn_i` high, bit 1 becomes 1 once `ref_smp_i` has shown no change for `stall_lim_i` consecutive system clocks (limit at least 1).
- R8: A change of `ref_smp_i` clears bit 1 one clock later and restarts the count.
- R9: With `fb_conn_i` low, bit 1 reads 0. If the stall limit was reached while feedback was disconnected, bit 1 reads 1 one clock after `fb_conn_i` goes high.
- R10: The setting spans -255 to +255. Exactly 510 accepted decrements lead from +255 to -255 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ps_inc_i | input | 1 | Phase-shift increment strobe |
| ps_dec_i | input | 1 | Phase-shift decrement strobe |
| dly_full_i | input | 1 | Delay line reports all taps active |
| ref_smp_i | input | 1 | Reference clock sampled in the system domain |
| fb_conn_i | input | 1 | Feedback path connected |
| stall_lim_i | input | TMO_W | System clocks without a reference change before the stopped bit sets |
| status_o | output | 8 | Status word: bit 0 overflow, bit 1 reference stopped, bits 7:2 zero |

## Verification
Every status result is due exactly one system clock after the edge that samples its stimulus. This holds for overflow, for delay-full, for feedback gating and for reference-edge clearing. The stopped bit appears after the last of `stall_lim_i` quiet clocks. The bench drives inputs and samples `status_o` on the falling edge, so each comparison follows exactly one rising edge after its stimulus. A cycle model, built from the requirements, advances once per rising edge. The bench sweeps the full phase range in both directions and runs stall limits 1 through 6.

// File: rtl/clkmgr_status_pkg.sv
package clkmgr_status_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned BIT_OVF  = 0;
  localparam int unsigned BIT_STOP = 1;

  typedef enum logic [1:0] {
    PS_HOLD = 2'b00,
    PS_UP   = 2'b01,
    PS_DOWN = 2'b10
  } ps_req_e;
endpackage

// File: rtl/clkmgr_phase_track.sv
module clkmgr_phase_track
  import clkmgr_status_pkg::*;
#(
  parameter int unsigned LIMIT = 255
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic ovf_o
);
  localparam int unsigned VAL_W = $clog2(LIMIT + 1) + 1;
  localparam logic signed [VAL_W-1:0] POS_LIM = VAL_W'(LIMIT);
  localparam logic signed [VAL_W-1:0] NEG_LIM = -POS_LIM;
  localparam logic signed [VAL_W-1:0] ONE     = VAL_W'(1);

  logic signed [VAL_W-1:0] val_q;
  logic                    ovf_q;
  ps_req_e                 req;
  logic                    at_top, at_bot;

  always_comb begin
    unique case ({dec_i, inc_i})
      2'b01:   req = PS_UP;
      2'b10:   req = PS_DOWN;
      default: req = PS_HOLD;
    endcase
  end

  assign at_top = (val_q == POS_LIM);
  assign at_bot = (val_q == NEG_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      unique case (req)
        PS_UP: begin
          if (at_top) ovf_q <= 1'b1;
          else begin
            val_q <= val_q + ONE;
            ovf_q <= 1'b0;
          end
        end
        PS_DOWN: begin
          if (at_bot) ovf_q <= 1'b1;
          else begin
            val_q <= val_q - ONE;
            ovf_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign ovf_o = ovf_q;

  assert_in_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_q <= POS_LIM) && (val_q >= NEG_LIM));

  assert_reject_top_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && at_top) |=> ($stable(val_q) && ovf_q));

  assert_reject_bot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && at_bot) |=> ($stable(val_q) && ovf_q));

  assert_accept_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((inc_i && !dec_i && !at_top) || (dec_i && !inc_i && !at_bot)) |=> !ovf_q);

  assert_both_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> ($stable(val_q) && $stable(ovf_q)));
endmodule

// File: rtl/clkmgr_ref_watch.sv
module clkmgr_ref_watch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             stop_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             ref_q, stop_q, chg;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign chg     = ref_i ^ ref_q;
  assign cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      ref_q <= ref_i;
      if (chg) begin
        cnt_q  <= '0;
        stop_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_nxt;
        stop_q <= (cnt_nxt >= limit_i);
      end
    end
  end

  assign stop_o = stop_q;

  assert_edge_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> (!stop_q && cnt_q == '0));

  assert_quiet_counts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chg && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/clkmgr_status_mon.sv
module clkmgr_status_mon
  import clkmgr_status_pkg::*;
#(
  parameter int unsigned PS_LIMIT = 255,
  parameter int unsigned TMO_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ps_inc_i,
  input  logic              ps_dec_i,
  input  logic              dly_full_i,
  input  logic              ref_smp_i,
  input  logic              fb_conn_i,
  input  logic [TMO_W-1:0]  stall_lim_i,
  output logic [STAT_W-1:0] status_o
);
  logic range_ovf, ref_stop;
  logic full_q, fb_q;

  clkmgr_phase_track #(.LIMIT(PS_LIMIT)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ps_inc_i),
    .dec_i  (ps_dec_i),
    .ovf_o  (range_ovf)
  );

  clkmgr_ref_watch #(.CNT_W(TMO_W)) u_watch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_i   (ref_smp_i),
    .limit_i (stall_lim_i),
    .stop_o  (ref_stop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      fb_q   <= 1'b0;
    end else begin
      full_q <= dly_full_i;
      fb_q   <= fb_conn_i;
    end
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    if (b == BIT_OVF) begin : g_ovf
      assign status_o[b] = range_ovf | full_q;
    end else if (b == BIT_STOP) begin : g_stop
      assign status_o[b] = ref_stop & fb_q;
    end else begin : g_rsvd
      assign status_o[b] = 1'b0;
    end
  end

  assert_full_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_full_i |=> status_o[BIT_OVF]);

  assert_fb_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_conn_i |=> !status_o[BIT_STOP]);
endmodule

// File: tb/clkmgr_status_mon_bench.sv
`timescale 1ns/1ps
module clkmgr_status_mon_bench;
  localparam int LIM = 255;
  localparam int TW  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic inc = 1'b0, dec = 1'b0, full = 1'b0, refs = 1'b0, fb = 1'b0;
  logic [TW-1:0] lim = TW'(4);
  logic [7:0] status;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int m_val = 0, m_cnt = 0;
  bit m_ovf = 0, m_full = 0, m_ref = 0, m_stop = 0, m_fb = 0;

  always #2.5 clk = ~clk;

  clkmgr_status_mon #(.PS_LIMIT(LIM), .TMO_W(TW)) u_clkmgr_status_mon (
    .clk_i(clk), .rst_ni(rst_ni), .ps_inc_i(inc), .ps_dec_i(dec),
    .dly_full_i(full), .ref_smp_i(refs), .fb_conn_i(fb),
    .stall_lim_i(lim), .status_o(status)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: status actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_word();
    return {6'b0, m_stop & m_fb, m_ovf | m_full};
  endfunction

  task automatic step(string tag);
    if (inc && !dec) begin
      if (m_val == LIM) m_ovf = 1; else begin m_val++; m_ovf = 0; end
    end else if (dec && !inc) begin
      if (m_val == -LIM) m_ovf = 1; else begin m_val--; m_ovf = 0; end
    end
    if (refs != m_ref) begin m_cnt = 0; m_stop = 0; end
    else begin
      if (m_cnt < 65535) m_cnt++;
      m_stop = (m_cnt >= int'(lim));
    end
    m_ref = refs; m_full = full; m_fb = fb;
    @(posedge clk);
    @(negedge clk);
    chk(tag, status, expect_word());
    chk("R2", {status[7:2], 2'b00}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", status, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", status, 8'h00);

    // phase sweep up to +255
    inc = 1;
    repeat (LIM) step("R10");
    step("R3");
    chk("R3", {7'b0, status[0]}, 8'h01);
    step("R4");
    dec = 1;
    step("R5");
    chk("R5", {7'b0, status[0]}, 8'h01);
    inc = 0;
    step("R4");
    chk("R4", {7'b0, status[0]}, 8'h00);
    repeat (2 * LIM - 1) step("R10");
    step("R3");
    chk("R3", {7'b0, status[0]}, 8'h01);
    inc = 1;
    step("R5");
    dec = 0;
    step("R4");
    chk("R4", {7'b0, status[0]}, 8'h00);
    inc = 0;
    full = 1;
    step("R6");
    chk("R6", {7'b0, status[0]}, 8'h01);
    dec = 1;
    step("R6");
    dec = 0; full = 0;
    step("R6");
    chk("R6", {7'b0, status[0]}, 8'h00);

    // reference stall detection
    fb = 1;
    step("R9");
    for (int l = 1; l <= 6; l++) begin
      lim = TW'(l);
      refs = ~refs;
      step("R8");
      chk("R8", {6'b0, status[1], 1'b0}, 8'h00);
      repeat (l - 1) step("R7");
      chk("R7", {6'b0, status[1], 1'b0}, 8'h00);
      step("R7");
      chk("R7", {6'b0, status[1], 1'b0}, 8'h02);
    end
    for (int i = 0; i < 20; i++) begin
      refs = ~refs;
      step("R8");
    end
    lim = TW'(3);
    fb = 0;
    repeat (10) step("R9");
    chk("R9", {6'b0, status[1], 1'b0}, 8'h00);
    fb = 1;
    step("R9");
    chk("R9", {6'b0, status[1], 1'b0}, 8'h02);
    refs = ~refs;
    step("R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule